// File: doc/BRIEF.md
# Shared Storage Window Configuration and Address Decoder

This block holds the two 64-bit configuration words that place, enable and size a storage window used by an inter-thread communication array. Software reaches each word through its own 8-byte slot in a small tag register space. Writes are masked so that only the defined fields change. Every write that really alters a stored word produces a one-cycle reconfigure pulse, and at the same edge the window base, enable and size outputs take their new values.

A separate combinational decode port takes an offset into the storage window. It returns the cell that the offset selects, the access view carried in the offset, whether that view is one of the defined ones, and whether the offset falls inside the enabled window. The cell stride is set at run time by a grain field in the second word. An offset past the last cell selects the last cell and does not fault.

Top module: `comm_window_decoder`

## Requirements
- R1: After reset, word 0 reads 0, and word 1 reads 0xC00 with the total cell count (FIFO cells plus semaphore cells, 32 by default) at bit 20, so 0x2000C00 by default. The window is disabled with base 0 and size 4096, and reconfigure and error are low.
- R2: The tag register index is reg_addr shifted right by 3. A read of index 0 or 1 returns that word on reg_rdata in the same cycle. A read of any other index returns 0.
- R3: A write to index 0 changes only bits [31:10] (base) and bit 0 (enable). Every other bit keeps its old value.
- R4: A write to index 1 changes only bits [16:10] (address mask) and bits [2:0] (grain). The cell-count field at bit 20 and every other bit keep their old value.
- R5: A write to any index other than 0 or 1 changes no word and raises reg_err for exactly the next cycle, with no reconfigure pulse.
- R6: reconfig_pulse is high for one cycle after a write, and only when that write changed the stored word. A write of the value already held gives no pulse.
- R7: After a changing write, win_base equals word 0 bits [31:10] followed by ten zero bits, and win_en equals word 0 bit 0.
- R8: After a changing write, the candidate size is 1024 plus word 1 masked with 0x1FC00. win_size takes the candidate only if it is a power of two. Otherwise win_size keeps its previous value.
- R9: dec_cell_idx is dec_offset shifted right by 7 plus the grain field, which gives a stride of 128 bytes at grain 0.
- R10: If that shifted value is at or above the total cell count, dec_cell_idx is the last cell (count minus 1).
- R11: dec_view equals dec_offset bits [6:3]. dec_view_valid is high for codes 0 to 5 (raw, tag, queue wait, queue try, semaphore wait, semaphore try) and low for codes 6 to 15.
- R12: dec_window_hit is high only when win_en is high and dec_offset is below win_size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | TAG_AW | Byte address in the tag register space |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read-back of the addressed word, combinational |
| reg_err | output | 1 | One-cycle flag for a write to an unimplemented slot |
| reconfig_pulse | output | 1 | One-cycle pulse after a write that changed a word |
| win_base | output | 32 | Window base address |
| win_en | output | 1 | Window enable |
| win_size | output | 18 | Window size in bytes |
| dec_offset | input | OFF_W | Offset of an access into the storage window |
| dec_cell_idx | output | IDX_W | Selected cell, clamped |
| dec_view | output | 4 | View code from the offset |
| dec_view_valid | output | 1 | View code is one of the defined six |
| dec_window_hit | output | 1 | Offset lies inside the enabled window |

## Verification
The decode port is driven with offsets that separate the fields from one another. Some offsets differ only in bits [6:3], so a view error cannot hide behind a correct cell index. Other offsets land exactly on the cell-count boundary and the window-size boundary, and some lie far beyond both, which separates the clamp from the window hit. The grain is then changed so that a stride error appears as a different cell. Register writes are chosen to tell apart three cases: a masked field that changes, a write that leaves every word unchanged and must give no pulse, and a size candidate that is not a power of two and must leave the old size in place.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned SIZE_W  = 18;
    localparam int unsigned CNT_LSB = 20;

    localparam logic [WORD_W-1:0] W0_MASK = 64'h0000_0000_FFFF_FC01;
    localparam logic [WORD_W-1:0] W1_MASK = 64'h0000_0000_0001_FC07;
    localparam logic [WORD_W-1:0] W1_SIZE_FIELD = 64'h0000_0000_0001_FC00;
    localparam logic [WORD_W-1:0] W1_RESET_BASE = 64'h0000_0000_0000_0C00;
    localparam logic [SIZE_W-1:0] SIZE_FLOOR = 18'd1024;

    typedef enum logic [3:0] {
        VIEW_RAW        = 4'd0,
        VIEW_TAG        = 4'd1,
        VIEW_QUEUE_WAIT = 4'd2,
        VIEW_QUEUE_TRY  = 4'd3,
        VIEW_SEM_WAIT   = 4'd4,
        VIEW_SEM_TRY    = 4'd5
    } view_e;

    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [SIZE_W-1:0] size;
        logic              pulse;
        logic              err;
    } cfg_state_t;

    function automatic logic is_pow2(input logic [SIZE_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/cwd_cfg_regs.sv
module cwd_cfg_regs
    import cwd_pkg::*;
#(
    parameter int unsigned TAG_AW    = 8,
    parameter int unsigned NUM_CELLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [TAG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [WORD_W-1:0] w0,
    output logic [WORD_W-1:0] w1,
    output logic [SIZE_W-1:0] size,
    output logic              pulse,
    output logic              err
);

    localparam logic [WORD_W-1:0] W1_RESET =
        W1_RESET_BASE | (WORD_W'(NUM_CELLS) << CNT_LSB);
    localparam logic [SIZE_W-1:0] SIZE_RESET =
        SIZE_FLOOR + SIZE_W'(W1_RESET & W1_SIZE_FIELD);
    localparam cfg_state_t CFG_RESET = '{
        w0:    '0,
        w1:    W1_RESET,
        size:  SIZE_RESET,
        pulse: 1'b0,
        err:   1'b0
    };

    cfg_state_t cfg_d, cfg_q;

    logic [TAG_AW-1:0] slot;
    logic [WORD_W-1:0] cand_w0, cand_w1;
    logic [SIZE_W-1:0] cand_size;

    always_comb begin
        slot      = reg_addr >> 3;
        cfg_d     = cfg_q;
        cfg_d.pulse = 1'b0;
        cfg_d.err   = 1'b0;
        cand_w0   = cfg_q.w0;
        cand_w1   = cfg_q.w1;
        if (reg_valid && reg_write) begin
            if (slot == TAG_AW'(0)) begin
                cand_w0 = (reg_wdata & W0_MASK) | (cfg_q.w0 & ~W0_MASK);
            end else if (slot == TAG_AW'(1)) begin
                cand_w1 = (reg_wdata & W1_MASK) | (cfg_q.w1 & ~W1_MASK);
            end else begin
                cfg_d.err = 1'b1;
            end
        end
        cand_size = SIZE_FLOOR + SIZE_W'(cand_w1 & W1_SIZE_FIELD);
        if ((cand_w0 != cfg_q.w0) || (cand_w1 != cfg_q.w1)) begin
            cfg_d.w0    = cand_w0;
            cfg_d.w1    = cand_w1;
            cfg_d.pulse = 1'b1;
            if (is_pow2(cand_size)) begin
                cfg_d.size = cand_size;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        if (slot == TAG_AW'(0)) begin
            reg_rdata = cfg_q.w0;
        end else if (slot == TAG_AW'(1)) begin
            reg_rdata = cfg_q.w1;
        end else begin
            reg_rdata = '0;
        end
    end

    assign w0    = cfg_q.w0;
    assign w1    = cfg_q.w1;
    assign size  = cfg_q.size;
    assign pulse = cfg_q.pulse;
    assign err   = cfg_q.err;

endmodule

// File: rtl/cwd_cell_index.sv
module cwd_cell_index #(
    parameter int unsigned OFF_W     = 20,
    parameter int unsigned NUM_CELLS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [2:0]       grain,
    output logic [IDX_W-1:0] cell_idx
);

    localparam logic [IDX_W-1:0] LAST_CELL = IDX_W'(NUM_CELLS - 1);

    logic [3:0]       shift_amt;
    logic [OFF_W-1:0] raw_idx;
    logic             beyond;

    always_comb begin
        shift_amt = 4'd7 + {1'b0, grain};
        raw_idx   = offset >> shift_amt;
    end

    generate
        if (NUM_CELLS == (1 << IDX_W)) begin : g_pow2_count
            always_comb beyond = (raw_idx >> IDX_W) != '0;
        end else begin : g_any_count
            always_comb beyond = raw_idx >= OFF_W'(NUM_CELLS);
        end
    endgenerate

    always_comb begin
        cell_idx = beyond ? LAST_CELL : raw_idx[IDX_W-1:0];
    end

endmodule

// File: rtl/cwd_view_decode.sv
module cwd_view_decode
    import cwd_pkg::*;
(
    input  logic [3:0] view_bits,
    output logic [3:0] view,
    output logic       view_valid
);

    always_comb begin
        view = view_bits;
        unique case (view_bits)
            VIEW_RAW, VIEW_TAG, VIEW_QUEUE_WAIT,
            VIEW_QUEUE_TRY, VIEW_SEM_WAIT, VIEW_SEM_TRY: view_valid = 1'b1;
            default: view_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/comm_window_decoder.sv
module comm_window_decoder
    import cwd_pkg::*;
#(
    parameter int unsigned TAG_AW    = 8,
    parameter int unsigned OFF_W     = 20,
    parameter int unsigned NUM_FIFO  = 16,
    parameter int unsigned NUM_SEM   = 16,
    parameter int unsigned NUM_CELLS = NUM_FIFO + NUM_SEM,
    parameter int unsigned IDX_W     = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [TAG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    output logic              reconfig_pulse,
    output logic [31:0]       win_base,
    output logic              win_en,
    output logic [17:0]       win_size,
    input  logic [OFF_W-1:0]  dec_offset,
    output logic [IDX_W-1:0]  dec_cell_idx,
    output logic [3:0]        dec_view,
    output logic              dec_view_valid,
    output logic              dec_window_hit
);

    localparam int unsigned CMP_W = (OFF_W > SIZE_W) ? OFF_W : SIZE_W;

    logic [WORD_W-1:0] w0_q, w1_q;

    cwd_cfg_regs #(
        .TAG_AW   (TAG_AW),
        .NUM_CELLS(NUM_CELLS)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_valid(reg_valid),
        .reg_write(reg_write),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .w0       (w0_q),
        .w1       (w1_q),
        .size     (win_size),
        .pulse    (reconfig_pulse),
        .err      (reg_err)
    );

    assign win_base = {w0_q[31:10], 10'b0};
    assign win_en   = w0_q[0];

    cwd_cell_index #(
        .OFF_W    (OFF_W),
        .NUM_CELLS(NUM_CELLS),
        .IDX_W    (IDX_W)
    ) u_idx (
        .offset  (dec_offset),
        .grain   (w1_q[2:0]),
        .cell_idx(dec_cell_idx)
    );

    cwd_view_decode u_view (
        .view_bits (dec_offset[6:3]),
        .view      (dec_view),
        .view_valid(dec_view_valid)
    );

    always_comb begin
        dec_window_hit = win_en && (CMP_W'(dec_offset) < CMP_W'(win_size));
    end

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int unsigned TAG_AW    = 8,
    parameter int unsigned NUM_CELLS = 32,
    parameter int unsigned IDX_W     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [TAG_AW-1:0] reg_addr,
    input logic              reg_err,
    input logic              reconfig_pulse,
    input logic              win_en,
    input logic [17:0]       win_size,
    input logic [63:0]       w0_q,
    input logic [63:0]       w1_q,
    input logic [IDX_W-1:0]  dec_cell_idx,
    input logic              dec_window_hit
);

    localparam int unsigned CNT_W = $clog2(NUM_CELLS + 1);

    // R5
    bad_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && ((reg_addr >> 3) > TAG_AW'(1)))
        |=> (reg_err && !reconfig_pulse && $stable(w0_q) && $stable(w1_q)));

    // R6
    pulse_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig_pulse |-> ((w0_q != $past(w0_q)) || (w1_q != $past(w1_q))));

    // R4
    cell_count_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w1_q[20 +: CNT_W] == CNT_W'(NUM_CELLS));

    // R8
    size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win_size) == 1);

    // R8
    size_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_size != $past(win_size)) |-> reconfig_pulse);

    // R10
    index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dec_cell_idx) < NUM_CELLS);

    // R12
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_window_hit |-> win_en);

endmodule

bind comm_window_decoder cwd_checker #(
    .TAG_AW   (TAG_AW),
    .NUM_CELLS(NUM_CELLS),
    .IDX_W    (IDX_W)
) u_cwd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_valid     (reg_valid),
    .reg_write     (reg_write),
    .reg_addr      (reg_addr),
    .reg_err       (reg_err),
    .reconfig_pulse(reconfig_pulse),
    .win_en        (win_en),
    .win_size      (win_size),
    .w0_q          (w0_q),
    .w1_q          (w1_q),
    .dec_cell_idx  (dec_cell_idx),
    .dec_window_hit(dec_window_hit)
);

// File: tb/comm_window_decoder_bench.sv
module comm_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err, reconfig_pulse, win_en;
    logic [31:0] win_base;
    logic [17:0] win_size;
    logic [19:0] dec_offset = '0;
    logic [4:0]  dec_cell_idx;
    logic [3:0]  dec_view;
    logic        dec_view_valid, dec_window_hit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    comm_window_decoder u_comm_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .reconfig_pulse(reconfig_pulse), .win_base(win_base),
        .win_en(win_en), .win_size(win_size), .dec_offset(dec_offset),
        .dec_cell_idx(dec_cell_idx), .dec_view(dec_view),
        .dec_view_valid(dec_view_valid), .dec_window_hit(dec_window_hit)
    );

    typedef struct packed {
        logic [19:0] off;
        logic [4:0]  idx;
        logic [3:0]  view;
        logic        vv;
        logic        hit;
    } vec_t;

    // Window enabled, base 0, size 4096, grain 0, 32 cells.
    localparam vec_t VECS [9] = '{
        '{20'h00000, 5'd0,  4'd0,  1'b1, 1'b1},
        '{20'h00088, 5'd1,  4'd1,  1'b1, 1'b1},
        '{20'h00028, 5'd0,  4'd5,  1'b1, 1'b1},
        '{20'h00030, 5'd0,  4'd6,  1'b0, 1'b1},
        '{20'h000F8, 5'd1,  4'd15, 1'b0, 1'b1},
        '{20'h00F80, 5'd31, 4'd0,  1'b1, 1'b1},
        '{20'h00FFF, 5'd31, 4'd15, 1'b0, 1'b1},
        '{20'h01000, 5'd31, 4'd0,  1'b1, 1'b0},
        '{20'h05010, 5'd31, 4'd2,  1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_valid = 1'b1;
        reg_write = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0;
        reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic dec(input logic [19:0] off);
        dec_offset = off;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 word0", v, 64'h0);
        rd(8'h08, v); chk("R1 word1", v, 64'h2000C00);
        chk("R1 size", 64'(win_size), 64'd4096);
        chk("R1 enable", 64'(win_en), 64'd0);
        chk("R1 base", 64'(win_base), 64'd0);
        chk("R1 pulse/err", 64'({reconfig_pulse, reg_err}), 64'd0);
        dec(20'h0); chk("R12 hit when disabled", 64'(dec_window_hit), 64'd0);

        // R3, R6, R7 masked write to word 0
        do_write(8'h00, 64'hFFFF_FFFF_1234_5679);
        chk("R6 pulse on change", 64'(reconfig_pulse), 64'd1);
        rd(8'h00, v); chk("R3 word0 masked", v, 64'h1234_5401);
        chk("R7 base", 64'(win_base), 64'h1234_5400);
        chk("R7 enable", 64'(win_en), 64'd1);
        @(negedge clk);
        chk("R6 pulse one cycle", 64'(reconfig_pulse), 64'd0);
        do_write(8'h00, 64'h0000_0000_1234_57FD);
        chk("R6 no pulse on same value", 64'(reconfig_pulse), 64'd0);

        // R4, R8 word 1 writes
        do_write(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h08, v); chk("R4 word1 masked", v, 64'h201FC07);
        chk("R8 size max", 64'(win_size), 64'h20000);
        do_write(8'h08, 64'h800);
        chk("R6 pulse word1", 64'(reconfig_pulse), 64'd1);
        rd(8'h08, v); chk("R4 word1 field", v, 64'h2000800);
        chk("R8 non-pow2 keeps size", 64'(win_size), 64'h20000);
        do_write(8'h0D, 64'hC00);
        rd(8'h08, v); chk("R2 index from addr>>3", v, 64'h2000C00);
        chk("R8 size 4096", 64'(win_size), 64'd4096);

        // R5, R2 unimplemented slot
        do_write(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R5 err pulse", 64'(reg_err), 64'd1);
        chk("R5 no reconfig", 64'(reconfig_pulse), 64'd0);
        rd(8'h10, v); chk("R2 read unimplemented", v, 64'h0);
        rd(8'h00, v); chk("R5 word0 unchanged", v, 64'h1234_5401);
        rd(8'h08, v); chk("R5 word1 unchanged", v, 64'h2000C00);
        @(negedge clk);
        chk("R5 err one cycle", 64'(reg_err), 64'd0);

        // table walk: R9 R10 R11 R12
        do_write(8'h00, 64'h1);
        for (int i = 0; i < 9; i++) begin
            dec(VECS[i].off);
            chk("R9/R10 cell index", 64'(dec_cell_idx), 64'(VECS[i].idx));
            chk("R11 view", 64'(dec_view), 64'(VECS[i].view));
            chk("R11 view valid", 64'(dec_view_valid), 64'(VECS[i].vv));
            chk("R12 window hit", 64'(dec_window_hit), 64'(VECS[i].hit));
        end

        // R9 larger grain, R10 far clamp
        do_write(8'h08, 64'hC03);
        dec(20'h02400); chk("R9 grain 3 stride", 64'(dec_cell_idx), 64'd9);
        dec(20'h00400); chk("R9 grain 3 cell1", 64'(dec_cell_idx), 64'd1);
        dec(20'hFFFFF); chk("R10 far clamp", 64'(dec_cell_idx), 64'd31);
        chk("R12 far miss", 64'(dec_window_hit), 64'd0);
        dec(20'h00FFF); chk("R12 last byte hit", 64'(dec_window_hit), 64'd1);

        // R12 disabled window
        do_write(8'h00, 64'h0);
        dec(20'h0); chk("R12 disabled miss", 64'(dec_window_hit), 64'd0);
        chk("R7 enable cleared", 64'(win_en), 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule